// File: doc/BRIEF.md
# RTC Event Status Register

This block holds the eight-bit status byte of a real-time clock. Hardware elsewhere in the clock raises single-cycle event strobes: an alarm match, a daylight-saving forward step and a daylight-saving reverse step. It also presents level signals for conversion busy, oscillator failure, low core supply, two battery thresholds and a general clock failure. The register turns these into bits that software can read and clear through a simple synchronous read/write port, decoded at one address.

Three kinds of bit live in the byte. The first kind mirrors its input directly and ignores writes. The second kind is sticky: it is set by hardware and cleared only by software. The alarm flag is a sticky bit with extra rules. Software can clear it but never set it. A match that lands in the same cycle as a clear is not lost. With auto-clear enabled, a status read clears the flag, but only if the flag was set in the data that the read returned. The daylight-saving flag follows the forward and reverse events. Software may also load it. It is held at zero whenever daylight saving is disabled.

Top module: `rtc_status_reg`

## Requirements
- R1: After synchronous reset, `rd_data` is 0x00 and every sticky flag is 0, so a status read with all inputs low returns 0x00.
- R2: The status byte, from bit 7 down to bit 0, is: busy, oscillator fail, DST adjusted, alarm, supply low, battery-85 low, battery-75 low, clock fail. A read (`rd_en` high with `addr` = 0x07) loads `rd_data` at that clock edge with the byte as it stood before the edge. `rd_data` keeps its value when `rd_en` is low.
- R3: An `alarm_hit` strobe sets the alarm bit (bit 4) on the next edge. The bit then stays set until it is cleared.
- R4: A status write with bit 4 = 0 clears the alarm bit. A write with bit 4 = 1 never sets it.
- R5: With `alarm_autoclr` high, a status read that returns bit 4 = 1 clears the alarm bit afterwards. With `alarm_autoclr` low, reads leave the bit unchanged.
- R6: An `alarm_hit` in the same cycle as a status read or a clearing write leaves the alarm bit at 1 after that cycle.
- R7: With `dst_en` high, `dst_fwd` sets bit 5 and `dst_rev` clears it. When both strobes come in the same cycle, bit 5 clears.
- R8: While `dst_en` is low, bit 5 is forced to 0, and forward events and writes to bit 5 have no effect.
- R9: With `dst_en` high, a status write loads bit 5 from `wr_data[5]`. A DST event in the same cycle takes priority over the write.
- R10: The oscillator fail bit (6) and the clock fail bit (0) are set while their inputs are high and stay set after the inputs drop. A write of 0 to the bit clears it only if the input is low. A write of 1 has no effect.
- R11: Bits 7, 3, 2 and 1 show `busy_in`, `vdd_low_in`, `bat85_low_in` and `bat75_low_in` at the read edge, and writes do not change them.
- R12: A write to any address other than 0x07 changes no bit. A read of another address loads `rd_data` with 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register address for read and write |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| alarm_hit | input | 1 | Alarm match strobe |
| dst_fwd | input | 1 | Daylight-saving forward strobe |
| dst_rev | input | 1 | Daylight-saving reverse strobe |
| dst_en | input | 1 | Daylight saving enabled |
| alarm_autoclr | input | 1 | Clear alarm flag on read |
| busy_in | input | 1 | Temperature conversion in progress |
| osc_fail_in | input | 1 | Oscillator stopped |
| vdd_low_in | input | 1 | Core supply low |
| bat85_low_in | input | 1 | Battery below upper threshold |
| bat75_low_in | input | 1 | Battery below lower threshold |
| rtc_fail_in | input | 1 | Clock failure detected |

## Verification
The assertions assume that every input is synchronous to `clk` and free of unknown values once reset is released. They also assume that each event strobe stands for one event per cycle in which it is high, so a held strobe behaves like repeated events. The bench changes every input on the falling edge and holds it for whole cycles, and it gives each event strobe a single cycle. The cases where events coincide with reads, writes or each other are built on purpose, cycle by cycle, because the priority rules depend on them.

// File: rtl/rtc_stat_pkg.sv
package rtc_stat_pkg;

    localparam int STAT_W    = 8;
    localparam int BIT_RTCF  = 0;
    localparam int BIT_B75   = 1;
    localparam int BIT_B85   = 2;
    localparam int BIT_VDD   = 3;
    localparam int BIT_ALM   = 4;
    localparam int BIT_DST   = 5;
    localparam int BIT_OSC   = 6;
    localparam int BIT_BUSY  = 7;
    localparam int N_STICKY  = 2;

    // First member is the most significant bit.
    typedef struct packed {
        logic busy;
        logic osc_fail;
        logic dst_adj;
        logic alarm;
        logic vdd_low;
        logic bat85_low;
        logic bat75_low;
        logic rtc_fail;
    } stat_t;

    typedef struct packed {
        logic                rd;
        logic                wr;
        logic [STAT_W-1:0]   wdata;
    } acc_t;

    // Bit position owned by sticky flag slot i.
    function automatic int sticky_pos(input int i);
        return (i == 0) ? BIT_OSC : BIT_RTCF;
    endfunction

    // True when an access writes a 0 into bit pos.
    function automatic logic wr_zero(input acc_t a, input int pos);
        return a.wr && !a.wdata[pos];
    endfunction

endpackage

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag
    import rtc_stat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  acc_t acc,
    input  logic hit,
    input  logic autoclr,
    output logic flag
);
    logic wr_clr;
    logic rd_clr;

    always_comb begin
        wr_clr = wr_zero(acc, BIT_ALM);
        rd_clr = acc.rd && autoclr && flag;
    end

    // A new match wins over any clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (hit)
            flag <= 1'b1;
        else if (wr_clr || rd_clr)
            flag <= 1'b0;
    end

    p_alarm_sets_r3: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag);
    p_no_sw_set_r4: assert property (@(posedge clk) disable iff (rst)
        (!flag && !hit) |=> !flag);
    p_autoclr_r5: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && autoclr && flag && !hit) |=> !flag);
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (flag && !acc.rd && !acc.wr) |=> flag);

endmodule

// File: rtl/rtc_dst_flag.sv
module rtc_dst_flag
    import rtc_stat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  acc_t acc,
    input  logic enable,
    input  logic fwd,
    input  logic rev,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst || !enable)
            flag <= 1'b0;
        else if (rev)
            flag <= 1'b0;
        else if (fwd)
            flag <= 1'b1;
        else if (acc.wr)
            flag <= acc.wdata[BIT_DST];
    end

    p_disabled_r8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !flag);
    p_fwd_r7: assert property (@(posedge clk) disable iff (rst)
        (enable && fwd && !rev) |=> flag);
    p_rev_r7: assert property (@(posedge clk) disable iff (rst)
        (enable && rev) |=> !flag);
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (enable && !fwd && !rev && !acc.wr) |=> $stable(flag));

endmodule

// File: rtl/rtc_sticky_flag.sv
module rtc_sticky_flag
    import rtc_stat_pkg::*;
#(
    parameter int POS = BIT_OSC
) (
    input  logic clk,
    input  logic rst,
    input  acc_t acc,
    input  logic fail_in,
    output logic flag
);
    logic clr;

    always_comb clr = wr_zero(acc, POS);

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (fail_in)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    p_sticky_set_r10: assert property (@(posedge clk) disable iff (rst)
        fail_in |=> flag);
    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (flag && !acc.wr) |=> flag);

endmodule

// File: rtl/rtc_status_reg.sv
module rtc_status_reg
    import rtc_stat_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 'h07
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] rd_data,
    input  logic              alarm_hit,
    input  logic              dst_fwd,
    input  logic              dst_rev,
    input  logic              dst_en,
    input  logic              alarm_autoclr,
    input  logic              busy_in,
    input  logic              osc_fail_in,
    input  logic              vdd_low_in,
    input  logic              bat85_low_in,
    input  logic              bat75_low_in,
    input  logic              rtc_fail_in
);
    logic                sel;
    acc_t                acc;
    stat_t               stat;
    logic                alm_q;
    logic                dst_q;
    logic [N_STICKY-1:0] fail_in;
    logic [N_STICKY-1:0] sticky_q;

    always_comb begin
        sel       = (addr == STAT_ADDR);
        acc.rd    = rd_en && sel;
        acc.wr    = wr_en && sel;
        acc.wdata = wr_data;
        fail_in   = {rtc_fail_in, osc_fail_in};
    end

    rtc_alarm_flag u_alarm (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .hit     (alarm_hit),
        .autoclr (alarm_autoclr),
        .flag    (alm_q)
    );

    rtc_dst_flag u_dst (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc),
        .enable (dst_en),
        .fwd    (dst_fwd),
        .rev    (dst_rev),
        .flag   (dst_q)
    );

    for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
        rtc_sticky_flag #(.POS(sticky_pos(i))) u_flag (
            .clk     (clk),
            .rst     (rst),
            .acc     (acc),
            .fail_in (fail_in[i]),
            .flag    (sticky_q[i])
        );
    end

    always_comb begin
        stat.busy      = busy_in;
        stat.osc_fail  = sticky_q[0];
        stat.dst_adj   = dst_q;
        stat.alarm     = alm_q;
        stat.vdd_low   = vdd_low_in;
        stat.bat85_low = bat85_low_in;
        stat.bat75_low = bat75_low_in;
        stat.rtc_fail  = sticky_q[1];
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= sel ? stat : '0;
    end

    p_rd_other_r12: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !sel) |=> (rd_data == '0));
    p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
    p_rd_alarm_r2: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && alm_q) |=> rd_data[BIT_ALM]);

endmodule

// File: tb/tb_rtc_status_reg.sv
`timescale 1ns/1ps
module tb_rtc_status_reg;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] addr;
    logic       rd_en, wr_en;
    logic [7:0] wr_data, rd_data;
    logic       alarm_hit, dst_fwd, dst_rev, dst_en, alarm_autoclr;
    logic       busy_in, osc_fail_in, vdd_low_in, bat85_low_in, bat75_low_in, rtc_fail_in;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #4 clk = ~clk;

    rtc_status_reg dut (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .alarm_hit(alarm_hit),
        .dst_fwd(dst_fwd), .dst_rev(dst_rev), .dst_en(dst_en),
        .alarm_autoclr(alarm_autoclr), .busy_in(busy_in),
        .osc_fail_in(osc_fail_in), .vdd_low_in(vdd_low_in),
        .bat85_low_in(bat85_low_in), .bat75_low_in(bat75_low_in),
        .rtc_fail_in(rtc_fail_in)
    );

    // [19:16] busy,vdd,b85,b75  [15:8] write data  [7:0] expected read
    localparam logic [19:0] VEC [0:5] = '{
        {4'b1000, 8'h00, 8'h80},
        {4'b0100, 8'hFF, 8'h08},
        {4'b0010, 8'h00, 8'h04},
        {4'b0001, 8'hAA, 8'h02},
        {4'b1111, 8'h00, 8'h8E},
        {4'b0101, 8'h55, 8'h0A}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic idle();
        rd_en = 0; wr_en = 0; addr = 8'h07;
        alarm_hit = 0; dst_fwd = 0; dst_rev = 0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1;
        @(negedge clk); wr_en = 0; addr = 8'h07;
    endtask

    task automatic do_read(input logic [7:0] a, input string tag, input logic [7:0] exp);
        @(negedge clk); addr = a; rd_en = 1;
        @(negedge clk); rd_en = 0; addr = 8'h07;
        check(tag, rd_data, exp);
    endtask

    task automatic pulse_alarm();
        @(negedge clk); alarm_hit = 1;
        @(negedge clk); alarm_hit = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        wr_data = 0; dst_en = 0; alarm_autoclr = 0;
        busy_in = 0; osc_fail_in = 0; vdd_low_in = 0;
        bat85_low_in = 0; bat75_low_in = 0; rtc_fail_in = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        check("R1 rd_data at reset", rd_data, 8'h00);
        rst = 0;
        do_read(8'h07, "R1 first read", 8'h00);

        // R2 / R11: bit layout of level bits, writes ignored
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            {busy_in, vdd_low_in, bat85_low_in, bat75_low_in} = VEC[i][19:16];
            do_write(8'h07, VEC[i][15:8]);
            do_read(8'h07, "R2 R11 level vector", VEC[i][7:0]);
        end
        @(negedge clk);
        {busy_in, vdd_low_in, bat85_low_in, bat75_low_in} = 4'b0;

        // R3 alarm sets and holds
        pulse_alarm();
        do_read(8'h07, "R3 alarm set", 8'h10);
        do_read(8'h07, "R3 alarm held", 8'h10);
        // R4 write 1 does not set, write 0 clears
        do_write(8'h07, 8'hFF);
        do_read(8'h07, "R4 write one keeps", 8'h10);
        do_write(8'h07, 8'hEF);
        do_read(8'h07, "R4 write zero clears", 8'h00);
        do_write(8'h07, 8'h10);
        do_read(8'h07, "R4 write one no set", 8'h00);

        // R5 auto-clear on read
        alarm_autoclr = 1;
        pulse_alarm();
        do_read(8'h07, "R5 read returns alarm", 8'h10);
        do_read(8'h07, "R5 cleared after read", 8'h00);

        // R6 alarm during read
        @(negedge clk); rd_en = 1; alarm_hit = 1;
        @(negedge clk); rd_en = 0; alarm_hit = 0;
        check("R6 read during alarm", rd_data, 8'h00);
        do_read(8'h07, "R6 alarm kept", 8'h10);
        do_read(8'h07, "R5 cleared again", 8'h00);
        alarm_autoclr = 0;
        // R6 alarm during clearing write
        pulse_alarm();
        @(negedge clk); wr_en = 1; wr_data = 8'h00; alarm_hit = 1;
        @(negedge clk); wr_en = 0; alarm_hit = 0;
        do_read(8'h07, "R6 alarm beats write clear", 8'h10);
        do_write(8'h07, 8'h00);

        // R7 DST events
        dst_en = 1;
        @(negedge clk); dst_fwd = 1;
        @(negedge clk); dst_fwd = 0;
        do_read(8'h07, "R7 forward sets", 8'h20);
        @(negedge clk); dst_rev = 1;
        @(negedge clk); dst_rev = 0;
        do_read(8'h07, "R7 reverse clears", 8'h00);
        @(negedge clk); dst_fwd = 1; dst_rev = 1;
        @(negedge clk); dst_fwd = 0; dst_rev = 0;
        do_read(8'h07, "R7 both clears", 8'h00);

        // R8 disabled
        @(negedge clk); dst_fwd = 1;
        @(negedge clk); dst_fwd = 0; dst_en = 0;
        do_read(8'h07, "R8 disable forces zero", 8'h00);
        @(negedge clk); dst_fwd = 1;
        @(negedge clk); dst_fwd = 0;
        do_write(8'h07, 8'h20);
        do_read(8'h07, "R8 events and writes ignored", 8'h00);

        // R9 software load
        dst_en = 1;
        do_write(8'h07, 8'h30);
        do_read(8'h07, "R9 write sets", 8'h20);
        do_write(8'h07, 8'h10);
        do_read(8'h07, "R9 write clears", 8'h00);
        @(negedge clk); wr_en = 1; wr_data = 8'h20; dst_rev = 1;
        @(negedge clk); wr_en = 0; dst_rev = 0;
        do_read(8'h07, "R9 event beats write", 8'h00);
        dst_en = 0;

        // R10 sticky failure bits
        @(negedge clk); osc_fail_in = 1;
        @(negedge clk); osc_fail_in = 0;
        do_read(8'h07, "R10 osc sticky", 8'h40);
        do_write(8'h07, 8'hFF);
        do_read(8'h07, "R10 write one no effect", 8'h40);
        do_write(8'h07, 8'hBF);
        do_read(8'h07, "R10 osc cleared", 8'h00);
        @(negedge clk); rtc_fail_in = 1;
        do_write(8'h07, 8'h00);
        do_read(8'h07, "R10 clear blocked while high", 8'h01);
        @(negedge clk); rtc_fail_in = 0;
        do_read(8'h07, "R10 rtcf held after drop", 8'h01);
        do_write(8'h07, 8'hFE);
        do_read(8'h07, "R10 rtcf cleared", 8'h00);

        // R12 other addresses
        pulse_alarm();
        do_write(8'h06, 8'h00);
        do_read(8'h07, "R12 foreign write ignored", 8'h10);
        do_read(8'h08, "R12 foreign read zero", 8'h00);
        do_read(8'h07, "R12 alarm still set", 8'h10);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule